// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. Software-side logic hands over one character at a time with a write strobe. The character waits in a one-deep holding register until the shift stage is free. It is then framed and sent as a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. Each bit is held on the line until the next baud tick. The baud tick comes from outside the block.

Two status flags report progress. The holding-register-empty flag shows that another character can be written. The frame-done flag shows that the line went quiet with nothing left to send. Each flag drives an interrupt output that is gated by its own enable and by a global interrupt enable. In 9-bit mode the ninth data bit is taken from a separate input. That input is captured together with the low byte at the write strobe, so it must be set up beforehand.

The `tx_drive` output tells the pin logic that the transmitter owns the line. Dropping the enable does not release the line at once. The line is released only after the holding register and the shift stage have both drained.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, `dre_flag` is 1, `txc_flag` is 0, both interrupts are 0, and `tx_drive` equals `tx_en`.
- R2: A frame is a 0 start bit followed by the data bits, LSB first. `char_size` selects the data width: 000 = 5, 001 = 6, 010 = 7, 011 = 8, 111 = 9. The unused codes 100, 101 and 110 give 8 bits. Every bit is held until a `baud_tick` cycle, and the frame begins on the cycle after the character enters the shift stage.
- R3: `parity_mode` 10 appends an even parity bit and 11 appends an odd parity bit, each computed over the sent data bits and placed right after the last data bit. Codes 00 and 01 send no parity bit.
- R4: `two_stop` 0 sends one high stop bit and 1 sends two.
- R5: The ninth data bit is the value of `bit9_in` in the cycle of the accepted write. Later changes of `bit9_in` do not alter that character.
- R6: A write is accepted only when `wr_stb`, `tx_en` and `dre_flag` are all 1; any other write is ignored. `dre_flag` falls on the cycle after an accepted write. When the shift stage is idle, the held character moves into it on the next edge and `dre_flag` rises again.
- R7: `txc_flag` is set when the last stop bit ends while the holding register is empty. An accepted write clears it.
- R8: `tx_drive` is 1 while `tx_en` is 1, a character is held, or a frame is in progress. After `tx_en` falls it stays 1 until both stages are empty.
- R9: `txd` is 1 whenever no frame is in progress.
- R10: `dre_irq` = `dre_flag` AND `dre_ie` AND `gie`; `txc_irq` = `txc_flag` AND `txc_ie` AND `gie`.
- R11: Size, parity and stop settings are sampled when a character enters the shift stage. Changing them during the frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| char_size | input | 3 | Data width code |
| parity_mode | input | 2 | Parity code |
| two_stop | input | 1 | Two stop bits when 1 |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Low data byte |
| bit9_in | input | 1 | Ninth data bit, captured at the write |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| gie | input | 1 | Global interrupt enable |
| dre_ie | input | 1 | Holding-register-empty interrupt enable |
| txc_ie | input | 1 | Frame-done interrupt enable |
| txd | output | 1 | Serial output |
| tx_drive | output | 1 | Transmitter owns the line |
| dre_flag | output | 1 | Holding register empty |
| txc_flag | output | 1 | Transmission complete |
| dre_irq | output | 1 | Gated empty interrupt |
| txc_irq | output | 1 | Gated complete interrupt |

## Verification
Single characters are sent under each width code (including a reserved code), each parity code and both stop settings. This separates faults in bit order, width decode, parity sense and stop count. Back-to-back writes, a write into a full holding register and a settings change in mid-frame show the difference between correct chaining and a lost or altered character. A toggle of the ninth-bit input after the write tests R5. Dropping the enable with one frame in flight and one pending shows whether line release is deferred. Sweeping the enable combinations shows whether each interrupt is gated by all three terms.

// File: rtl/sertx_pkg.sv
// Shared constants and helpers for the serial transmitter.
// Assumes at most 9 data bits, optional parity, and up to 2 stop bits.
package sertx_pkg;
    localparam int MAX_DATA = 9;
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    // Map the 3-bit width code to a data bit count (reserved codes give 8).
    function automatic logic [3:0] data_bits(input logic [2:0] code);
        case (code)
            3'b000:  data_bits = 4'd5;
            3'b001:  data_bits = 4'd6;
            3'b010:  data_bits = 4'd7;
            3'b111:  data_bits = 4'd9;
            default: data_bits = 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/sertx_holdreg.sv
// One-deep holding register between the write port and the shift stage.
// Assumes load and take are never asserted in the same cycle.
module sertx_holdreg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         take_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);
    // Capture a character on load and release it on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            data_o <= '0;
        end else if (take_i) begin
            full_o <= 1'b0;
        end else if (load_i) begin
            full_o <= 1'b1;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/sertx_framer.sv
// Builds a frame (start, data LSB first, optional parity, stop bits) and
// shifts it out one bit per baud tick. Settings are sampled at start_i.
// Assumes start_i is only raised while the framer is idle.
module sertx_framer
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_DATA-1:0] data_i,
    input  logic [2:0]          size_i,
    input  logic [1:0]          par_i,
    input  logic                two_stop_i,
    input  logic                tick_i,
    output logic                busy_o,
    output logic                txd_o,
    output logic                end_o
);
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   remain;
    logic [FRAME_W-1:0] frame_nx;
    logic [CNT_W-1:0]   len_nx;
    logic [3:0]         nbits;
    logic               par_on;
    logic               par_bit;

    // Assemble the frame image and its length from the current settings.
    always_comb begin
        nbits   = data_bits(size_i);
        par_on  = par_i[1];
        par_bit = par_i[0];
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(nbits)) par_bit = par_bit ^ data_i[i];
        end
        frame_nx    = '1;
        frame_nx[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(nbits)) frame_nx[1 + i] = data_i[i];
        end
        if (par_on) frame_nx[1 + int'(nbits)] = par_bit;
        len_nx = CNT_W'(nbits) + CNT_W'(1) + CNT_W'(par_on)
               + (two_stop_i ? CNT_W'(2) : CNT_W'(1));
    end

    // Load a new frame or advance the current one on a baud tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            shreg  <= '1;
            remain <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            shreg  <= frame_nx;
            remain <= len_nx - CNT_W'(1);
        end else if (busy_o && tick_i) begin
            shreg  <= {1'b1, shreg[FRAME_W-1:1]};
            remain <= remain - CNT_W'(1);
            if (remain == '0) busy_o <= 1'b0;
        end
    end

    assign end_o = busy_o && tick_i && (remain == '0);
    assign txd_o = busy_o ? shreg[0] : 1'b1;
endmodule

// File: rtl/sertx_flags.sv
// Frame-done flag register and interrupt gating for both status flags.
// Assumes wr_ok_i marks an accepted write to the holding register.
module sertx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end_i,
    input  logic buf_full_i,
    input  logic wr_ok_i,
    input  logic dre_flag_i,
    input  logic gie_i,
    input  logic dre_ie_i,
    input  logic txc_ie_i,
    output logic txc_o,
    output logic dre_irq_o,
    output logic txc_irq_o
);
    // Set on a quiet end of frame, clear on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         txc_o <= 1'b0;
        else if (wr_ok_i)                   txc_o <= 1'b0;
        else if (frame_end_i && !buf_full_i) txc_o <= 1'b1;
    end

    assign dre_irq_o = dre_flag_i & dre_ie_i & gie_i;
    assign txc_irq_o = txc_o & txc_ie_i & gie_i;
endmodule

// File: rtl/sertx_core.sv
// Top of the serial transmitter: holding register, framer and flags.
// Assumes baud_tick is a single-cycle pulse from an external divider.
module sertx_core
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic [2:0] char_size,
    input  logic [1:0] parity_mode,
    input  logic       two_stop,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       bit9_in,
    input  logic       baud_tick,
    input  logic       gie,
    input  logic       dre_ie,
    input  logic       txc_ie,
    output logic       txd,
    output logic       tx_drive,
    output logic       dre_flag,
    output logic       txc_flag,
    output logic       dre_irq,
    output logic       txc_irq
);
    logic                buf_full;
    logic [MAX_DATA-1:0] buf_data;
    logic                wr_ok;
    logic                take;
    logic                fr_busy;
    logic                fr_end;

    assign wr_ok    = wr_stb & tx_en & ~buf_full;
    assign take     = buf_full & ~fr_busy;
    assign dre_flag = ~buf_full;
    assign tx_drive = tx_en | buf_full | fr_busy;

    sertx_holdreg #(.W(MAX_DATA)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wr_ok),
        .data_i ({bit9_in, wr_data}),
        .take_i (take),
        .full_o (buf_full),
        .data_o (buf_data)
    );

    sertx_framer i_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (take),
        .data_i     (buf_data),
        .size_i     (char_size),
        .par_i      (parity_mode),
        .two_stop_i (two_stop),
        .tick_i     (baud_tick),
        .busy_o     (fr_busy),
        .txd_o      (txd),
        .end_o      (fr_end)
    );

    sertx_flags i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end_i (fr_end),
        .buf_full_i  (buf_full),
        .wr_ok_i     (wr_ok),
        .dre_flag_i  (dre_flag),
        .gie_i       (gie),
        .dre_ie_i    (dre_ie),
        .txc_ie_i    (txc_ie),
        .txc_o       (txc_flag),
        .dre_irq_o   (dre_irq),
        .txc_irq_o   (txc_irq)
    );
endmodule

// File: rtl/sertx_chk.sv
// Property checker for sertx_core, attached through bind.
// Assumes access to the framer busy signal of the top.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_stb,
    input logic gie,
    input logic dre_ie,
    input logic txc_ie,
    input logic txd,
    input logic dre_flag,
    input logic txc_flag,
    input logic dre_irq,
    input logic txc_irq,
    input logic busy
);
    AST_DRE_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        dre_irq |-> (dre_flag && dre_ie && gie)); // R10
    AST_TXC_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        txc_irq |-> (txc_flag && txc_ie && gie)); // R10
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R9
    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_en && dre_flag) |=> !dre_flag); // R6
    AST_WRITE_CLEARS_TXC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_en && dre_flag) |=> !txc_flag); // R7
    AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dre_flag) |=> (busy && dre_flag)); // R6
endmodule

bind sertx_core sertx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .wr_stb   (wr_stb),
    .gie      (gie),
    .dre_ie   (dre_ie),
    .txc_ie   (txc_ie),
    .txd      (txd),
    .dre_flag (dre_flag),
    .txc_flag (txc_flag),
    .dre_irq  (dre_irq),
    .txc_irq  (txc_irq),
    .busy     (fr_busy)
);

// File: tb/test_sertx_core.sv
// Bench for sertx_core: a queue-based reference model stepped every clock.
module test_sertx_core;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [2:0] char_size = 3'b011;
    logic [1:0] parity_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit9_in = 1'b0;
    logic       baud_tick = 1'b0;
    logic       gie = 1'b0;
    logic       dre_ie = 1'b0;
    logic       txc_ie = 1'b0;
    logic       txd, tx_drive, dre_flag, txc_flag, dre_irq, txc_irq;

    int n_checks = 0;
    int n_fail = 0;

    sertx_core i_sertx_core (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .char_size(char_size),
        .parity_mode(parity_mode), .two_stop(two_stop), .wr_stb(wr_stb),
        .wr_data(wr_data), .bit9_in(bit9_in), .baud_tick(baud_tick),
        .gie(gie), .dre_ie(dre_ie), .txc_ie(txc_ie), .txd(txd),
        .tx_drive(tx_drive), .dre_flag(dre_flag), .txc_flag(txc_flag),
        .dre_irq(dre_irq), .txc_irq(txc_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    bit m_full, m_busy, m_txc, m_pre_full, m_accept, m_fend, m_par;
    int m_data, m_n;
    bit m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_full = 0; m_busy = 0; m_txc = 0; m_bits.delete();
        end else begin
            m_pre_full = m_full;
            m_accept = tx_en && wr_stb && !m_full;
            m_fend = m_busy && baud_tick && (m_bits.size() == 1);
            if (m_busy) begin
                if (baud_tick) begin
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) m_busy = 0;
                end
            end else if (m_full) begin
                case (char_size)
                    3'b000: m_n = 5; 3'b001: m_n = 6; 3'b010: m_n = 7;
                    3'b111: m_n = 9; default: m_n = 8;
                endcase
                m_bits.delete();
                m_bits.push_back(1'b0);
                m_par = parity_mode[0];
                for (int i = 0; i < m_n; i++) begin
                    m_bits.push_back(m_data[i]);
                    m_par = m_par ^ m_data[i];
                end
                if (parity_mode[1]) m_bits.push_back(m_par);
                m_bits.push_back(1'b1);
                if (two_stop) m_bits.push_back(1'b1);
                m_busy = 1; m_full = 0;
            end
            if (m_accept) m_txc = 0;
            else if (m_fend && !m_pre_full) m_txc = 1;
            if (m_accept) begin
                m_full = 1;
                m_data = {23'd0, bit9_in, wr_data};
            end
        end
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R3/R4/R9 txd", int'(txd), m_busy ? int'(m_bits[0]) : 1);
            check("R8 tx_drive", int'(tx_drive), int'(tx_en | m_full | m_busy));
            check("R6 dre_flag", int'(dre_flag), int'(!m_full));
            check("R7 txc_flag", int'(txc_flag), int'(m_txc));
            check("R10 dre_irq", int'(dre_irq), int'(!m_full && dre_ie && gie));
            check("R10 txc_irq", int'(txc_irq), int'(m_txc && txc_ie && gie));
        end
    end

    // Free-running baud tick
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk); #1;
            baud_tick = (cnt == TICK_DIV - 1);
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic put(input logic [7:0] d, input logic b9);
        wr_data = d; bit9_in = b9; wr_stb = 1'b1;
        cyc(1);
        wr_stb = 1'b0;
    endtask

    task automatic wait_drained();
        while (m_full || m_busy) cyc(1);
        cyc(2);
    endtask

    task automatic send(input logic [2:0] sz, input logic [1:0] pm, input logic ts,
                        input logic [7:0] d, input logic b9);
        char_size = sz; parity_mode = pm; two_stop = ts;
        put(d, b9);
        wait_drained();
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", int'(txd), 1);
        check("R1 tx_drive", int'(tx_drive), 0);
        check("R1 dre_flag", int'(dre_flag), 1);
        check("R1 txc_flag", int'(txc_flag), 0);
        check("R1 irqs", int'(dre_irq | txc_irq), 0);
        cyc(1);
        // R6 write while disabled is ignored
        put(8'h3C, 1'b0);
        @(negedge clk);
        check("R6 ignored write", int'(dre_flag), 1);
        cyc(1);
        tx_en = 1'b1; gie = 1'b1; dre_ie = 1'b1; txc_ie = 1'b1;
        cyc(2);
        // R2 widths, R3 parity, R4 stop bits
        send(3'b011, 2'b00, 1'b0, 8'hA5, 1'b0);
        @(negedge clk);
        check("R7 txc after quiet end", int'(txc_flag), 1);
        cyc(1);
        send(3'b000, 2'b10, 1'b0, 8'h1B, 1'b0);
        send(3'b010, 2'b11, 1'b1, 8'h5A, 1'b0);
        send(3'b001, 2'b01, 1'b0, 8'h2E, 1'b0);
        send(3'b101, 2'b10, 1'b1, 8'hF0, 1'b0);
        // R5 ninth bit captured at the write, later change has no effect
        char_size = 3'b111; parity_mode = 2'b11; two_stop = 1'b0;
        put(8'h81, 1'b1);
        bit9_in = 1'b0;
        wait_drained();
        send(3'b111, 2'b10, 1'b1, 8'h7E, 1'b0);
        // R6 back-to-back writes and a write into a full buffer
        char_size = 3'b011; parity_mode = 2'b00; two_stop = 1'b0;
        put(8'h11, 1'b0);
        put(8'h22, 1'b0);
        put(8'h33, 1'b0);
        put(8'h44, 1'b0);
        wait_drained();
        // R11 settings changed mid-frame affect only the next frame
        put(8'hC3, 1'b0);
        cyc(3);
        char_size = 3'b000; parity_mode = 2'b11; two_stop = 1'b1;
        put(8'h96, 1'b0);
        wait_drained();
        // R10 gating combinations
        gie = 1'b0; cyc(2);
        gie = 1'b1; dre_ie = 1'b0; cyc(2);
        txc_ie = 1'b0; dre_ie = 1'b1; cyc(2);
        txc_ie = 1'b1; cyc(2);
        // R8 deferred disable with one frame in flight and one pending
        char_size = 3'b011; parity_mode = 2'b10; two_stop = 1'b1;
        put(8'h5C, 1'b0);
        cyc(2);
        put(8'hE7, 1'b0);
        tx_en = 1'b0;
        @(negedge clk);
        check("R8 drive held while draining", int'(tx_drive), 1);
        cyc(1);
        put(8'h99, 1'b0);
        wait_drained();
        @(negedge clk);
        check("R8 drive released", int'(tx_drive), 0);
        check("R9 line idle high", int'(txd), 1);
        check("R7 txc after drain", int'(txc_flag), 1);
        cyc(2);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule